// File: doc/BRIEF.md
# JTAG Debug Port Access Engine

This block is the target side of a debug port that a JTAG probe reaches through two data-register scan chains. One chain reaches the debug port's own registers and the other reaches an access port. An external TAP controller supplies the instruction register value and the capture, shift and update strobes. Each scan is 35 bits long. The low three bits carry a request on the way in and an acknowledge on the way out. The upper 32 bits carry write data in and read data out.

Requests on the access-port chain go out over a valid/ready request interface and come back on a response strobe. Only one access can be outstanding at a time. While it is outstanding, every scan captures a WAIT acknowledge and its own request is dropped. Reads are pipelined, so a read's data comes back in the capture of the next scan. The read-buffer register returns the last access-port read result without starting a new access. Overruns and faulted accesses set sticky status flags. While either flag is set, access-port requests are blocked.

Top module: `dp_jtag_engine`

## Requirements
- R1: After reset, no access-port request is pending, both power requests are low, tdo is 0, and all status, select and power-request fields read as zero.
- R2: A scan shifts 35 bits, least significant bit first on tdi and tdo. Bit 0 is the read flag (1 = read). Bits 2:1 are register address bits A[3:2]. Bits 34:3 are data.
- R3: Capture loads the acknowledge into bits 2:0. It is 3'b010 (OK) when no access is outstanding and 3'b001 (WAIT) while one is outstanding.
- R4: Read data appears in bits 34:3 of the next scan's capture, not in the scan that issued the read.
- R5: A debug-chain read at A=3 returns the last successful access-port read data and issues no access-port request. A debug-chain read at A=0 returns zero.
- R6: Debug-chain A=2 is the select register. Only bits 31:24 (port select) and 7:4 (bank) are stored. A request carries ap_req_sel = select[31:24] and ap_req_addr = {select[7:4], A[3:2], 2'b00}.
- R7: Debug-chain A=1 is control/status. Bit 30 drives sys_pwr_req and bit 28 drives dbg_pwr_req. Bits 31 and 29 read the sys_pwr_ack and dbg_pwr_ack inputs.
- R8: Control/status bit 0 enables overrun detection. Bit 1 is sticky overrun and bit 5 is sticky error. Writing 1 to a sticky bit clears it, and writing 0 leaves it unchanged.
- R9: The request of a scan whose capture returned WAIT is not executed. If overrun detection is on, that scan sets sticky overrun.
- R10: A response with ap_rsp_fault set sets sticky error and does not update the read buffer.
- R11: While either sticky flag is set, access-port requests are discarded with no request issued, and the acknowledge stays OK.
- R12: ap_req_valid and its fields hold steady until ap_req_ready is seen. Only one access is outstanding until its response.
- R13: Capture, shift and update strobes are ignored when the instruction value selects neither chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low reset |
| ir_value | input | IR_W | Current instruction register value |
| capture_dr | input | 1 | TAP in capture-DR |
| shift_dr | input | 1 | TAP in shift-DR |
| update_dr | input | 1 | TAP in update-DR |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| ap_req_valid | output | 1 | Access-port request valid |
| ap_req_ready | input | 1 | Access port accepts request |
| ap_req_sel | output | 8 | Access-port select |
| ap_req_addr | output | 8 | Access-port register byte address |
| ap_req_write | output | 1 | 1 = write |
| ap_req_wdata | output | 32 | Write data |
| ap_rsp_valid | input | 1 | Response strobe |
| ap_rsp_rdata | input | 32 | Response read data |
| ap_rsp_fault | input | 1 | Response faulted |
| sys_pwr_req | output | 1 | System power-up request |
| sys_pwr_ack | input | 1 | System power-up acknowledge |
| dbg_pwr_req | output | 1 | Debug power-up request |
| dbg_pwr_ack | input | 1 | Debug power-up acknowledge |

## Verification
The assertions assume four things about the inputs. The TAP strobes are one-hot and synchronous to clk. The access port asserts ap_rsp_valid only after it has accepted a request. It never responds twice to one request. The stimulus keeps to this: strobes are single-cycle pulses driven by one scan task, and a bench responder answers each accepted request exactly once after a programmable latency. Long latencies and a stalled ready provoke the WAIT, overrun and hold cases on purpose.

// File: rtl/dp_jtag_engine.sv
module dp_jtag_engine #(
  parameter int          IR_W  = 4,
  parameter logic [IR_W-1:0] IR_DP = 4'hA,
  parameter logic [IR_W-1:0] IR_AP = 4'hB
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IR_W-1:0] ir_value,
  input  logic            capture_dr,
  input  logic            shift_dr,
  input  logic            update_dr,
  input  logic            tdi,
  output logic            tdo,
  output logic            ap_req_valid,
  input  logic            ap_req_ready,
  output logic [7:0]      ap_req_sel,
  output logic [7:0]      ap_req_addr,
  output logic            ap_req_write,
  output logic [31:0]     ap_req_wdata,
  input  logic            ap_rsp_valid,
  input  logic [31:0]     ap_rsp_rdata,
  input  logic            ap_rsp_fault,
  output logic            sys_pwr_req,
  input  logic            sys_pwr_ack,
  output logic            dbg_pwr_req,
  input  logic            dbg_pwr_ack
);
  localparam int SCAN_W = 35;
  localparam logic [2:0] ACK_OK   = 3'b010;
  localparam logic [2:0] ACK_WAIT = 3'b001;

  logic [SCAN_W-1:0] sr;
  logic        waited, busy;
  logic [31:0] result, rdbuf;
  logic [7:0]  sel_port;
  logic [3:0]  sel_bank;
  logic        orun_en, st_orun, st_err;

  wire is_dp   = (ir_value == IR_DP);
  wire is_ap   = (ir_value == IR_AP);
  wire on_chain = is_dp | is_ap;
  wire cap     = capture_dr & on_chain;
  wire upd     = update_dr & on_chain;
  wire rnw     = sr[0];
  wire [1:0]  a   = sr[2:1];
  wire [31:0] wd  = sr[34:3];
  wire exec    = upd & ~waited;
  wire blocked = st_orun | st_err;
  wire dp_wr   = exec & is_dp & ~rnw;
  wire dp_rd   = exec & is_dp & rnw;
  wire ap_go   = exec & is_ap & ~blocked;
  wire rsp_take = ap_rsp_valid & busy;
  wire rsp_load = rsp_take & ~ap_rsp_fault & ~ap_req_write;

  wire [31:0] ctrl_rd = {sys_pwr_ack, sys_pwr_req, dbg_pwr_ack, dbg_pwr_req,
                         22'b0, st_err, 3'b0, st_orun, orun_en};
  wire [31:0] sel_rd  = {sel_port, 16'b0, sel_bank, 4'b0};

  assign tdo = sr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0;
      waited <= 1'b0;
    end else if (cap) begin
      sr <= {result, busy ? ACK_WAIT : ACK_OK};
      waited <= busy;
    end else if (shift_dr && on_chain) begin
      sr <= {tdi, sr[SCAN_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ap_req_valid <= 1'b0;
      ap_req_sel <= '0;
      ap_req_addr <= '0;
      ap_req_write <= 1'b0;
      ap_req_wdata <= '0;
    end else begin
      if (ap_go) begin
        busy <= 1'b1;
        ap_req_valid <= 1'b1;
        ap_req_sel <= sel_port;
        ap_req_addr <= {sel_bank, a, 2'b00};
        ap_req_write <= ~rnw;
        ap_req_wdata <= wd;
      end else begin
        if (ap_req_valid && ap_req_ready) ap_req_valid <= 1'b0;
        if (rsp_take) busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      rdbuf <= '0;
    end else begin
      if (dp_rd) begin
        case (a)
          2'd1:    result <= ctrl_rd;
          2'd2:    result <= sel_rd;
          2'd3:    result <= rdbuf;
          default: result <= '0;
        endcase
      end else if (rsp_load) begin
        result <= ap_rsp_rdata;
      end
      if (rsp_load) rdbuf <= ap_rsp_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_port <= '0;
      sel_bank <= '0;
      orun_en <= 1'b0;
      sys_pwr_req <= 1'b0;
      dbg_pwr_req <= 1'b0;
      st_orun <= 1'b0;
      st_err <= 1'b0;
    end else begin
      if (dp_wr && a == 2'd2) begin
        sel_port <= wd[31:24];
        sel_bank <= wd[7:4];
      end
      if (dp_wr && a == 2'd1) begin
        sys_pwr_req <= wd[30];
        dbg_pwr_req <= wd[28];
        orun_en <= wd[0];
      end
      if (upd && waited && orun_en) st_orun <= 1'b1;
      else if (dp_wr && a == 2'd1 && wd[1]) st_orun <= 1'b0;
      if (rsp_take && ap_rsp_fault) st_err <= 1'b1;
      else if (dp_wr && a == 2'd1 && wd[5]) st_err <= 1'b0;
    end
  end

  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ap_req_valid && !ap_req_ready |=> ap_req_valid && $stable(ap_req_addr) &&
                                      $stable(ap_req_sel) && $stable(ap_req_wdata));
  a_r3_wait_ack: assert property (@(posedge clk) disable iff (!rst_n)
    cap && busy |=> tdo);
  a_r3_ok_ack: assert property (@(posedge clk) disable iff (!rst_n)
    cap && !busy |=> !tdo);
  a_r11_sticky_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    upd && is_ap && blocked |=> !$rose(ap_req_valid));
  a_r5_dp_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    upd && is_dp |=> !$rose(ap_req_valid));
  a_r10_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ap_rsp_valid && ap_rsp_fault && busy |=> st_err);
  a_r9_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    upd && waited && orun_en |=> st_orun);
endmodule

// File: tb/dp_jtag_engine_tb_top.sv
module dp_jtag_engine_tb_top;
  localparam int CLK_P = 10;
  localparam logic [3:0] IR_DP = 4'hA;
  localparam logic [3:0] IR_AP = 4'hB;

  logic clk = 0, rst_n = 0;
  logic [3:0] ir_value = '0;
  logic capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
  logic tdo, ap_req_valid, ap_req_write, sys_pwr_req, dbg_pwr_req;
  logic [7:0] ap_req_sel, ap_req_addr;
  logic [31:0] ap_req_wdata;
  logic ap_rsp_valid = 0, ap_rsp_fault = 0;
  logic [31:0] ap_rsp_rdata = '0;
  logic [2:0] sys_d = '0, dbg_d = '0;
  logic rdy_en = 1;

  always #(CLK_P/2) clk = ~clk;

  dp_jtag_engine #(.IR_W(4), .IR_DP(IR_DP), .IR_AP(IR_AP)) dut_i (
    .clk(clk), .rst_n(rst_n), .ir_value(ir_value), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
    .ap_req_valid(ap_req_valid), .ap_req_ready(rdy_en), .ap_req_sel(ap_req_sel),
    .ap_req_addr(ap_req_addr), .ap_req_write(ap_req_write), .ap_req_wdata(ap_req_wdata),
    .ap_rsp_valid(ap_rsp_valid), .ap_rsp_rdata(ap_rsp_rdata), .ap_rsp_fault(ap_rsp_fault),
    .sys_pwr_req(sys_pwr_req), .sys_pwr_ack(sys_d[2]),
    .dbg_pwr_req(dbg_pwr_req), .dbg_pwr_ack(dbg_d[2]));

  int n_chk = 0, n_fail = 0, n_acc = 0;
  bit run = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural model state
  bit m_sys, m_dbg, m_oen, m_orun, m_err;
  logic [31:0] m_selv = '0, m_result = '0, m_rdbuf = '0;
  logic [48:0] q[$];
  logic [31:0] mem [256];
  int lat = 2, cnt = 0;
  bit pend = 0, force_fault = 0;
  logic [48:0] cur;

  always @(posedge clk) begin
    sys_d <= {sys_d[1:0], sys_pwr_req};
    dbg_d <= {dbg_d[1:0], dbg_pwr_req};
  end

  // access-port responder
  always @(posedge clk) begin
    ap_rsp_valid <= 1'b0;
    if (rst_n && ap_req_valid && rdy_en) begin
      n_acc++;
      cur = {ap_req_sel, ap_req_addr, ap_req_write, ap_req_wdata};
      if (q.size() == 0) chk("R11 unexpected request", {15'b0, cur[48:32]}, 32'hFFFF);
      else chk("R6 request fields", {15'b0, cur[48:32]}, {15'b0, q.pop_front()[48:32]});
      pend = 1; cnt = lat;
    end else if (pend) begin
      if (cnt > 0) cnt--;
      else begin
        pend = 0;
        ap_rsp_valid <= 1'b1;
        ap_rsp_fault <= force_fault;
        ap_rsp_rdata <= cur[32] ? 32'h0 : mem[cur[40:33]];
        if (force_fault) m_err = 1;
        else if (cur[32]) mem[cur[40:33]] = cur[31:0];
        else begin m_rdbuf = mem[cur[40:33]]; m_result = mem[cur[40:33]]; end
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (run) chk("R7 power request outputs", {30'b0, sys_pwr_req, dbg_pwr_req}, {30'b0, m_sys, m_dbg});
  end

  function automatic logic [31:0] ctrl_model();
    return {m_sys, m_sys, m_dbg, m_dbg, 22'b0, m_err, 3'b0, m_orun, m_oen};
  endfunction

  task automatic model_exec(input bit ap, input logic [1:0] a, input bit rnw,
                            input logic [31:0] wd, input bit waited);
    if (waited) begin
      if (m_oen) m_orun = 1;
      return;
    end
    if (!ap) begin
      case (a)
        2'd0: if (rnw) m_result = '0;
        2'd1: if (rnw) m_result = ctrl_model();
              else begin
                m_sys = wd[30]; m_dbg = wd[28]; m_oen = wd[0];
                if (wd[1]) m_orun = 0;
                if (wd[5]) m_err = 0;
              end
        2'd2: if (rnw) m_result = m_selv; else m_selv = wd & 32'hFF0000F0;
        default: if (rnw) m_result = m_rdbuf;
      endcase
    end else if (!(m_err || m_orun)) begin
      q.push_back({m_selv[31:24], m_selv[7:4], a, 2'b00, !rnw, wd});
    end
  endtask

  task automatic scan(input logic [3:0] irc, input logic [1:0] a, input bit rnw,
                      input logic [31:0] wd, input string tag);
    logic [34:0] din, dout;
    bit busy_c;
    logic [31:0] exp_d;
    din = {wd, a, rnw};
    @(negedge clk);
    ir_value = irc; capture_dr = 1;
    busy_c = ap_req_valid || pend || ap_rsp_valid;
    exp_d = m_result;
    @(negedge clk);
    capture_dr = 0; shift_dr = 1;
    for (int i = 0; i < 35; i++) begin
      dout[i] = tdo; tdi = din[i];
      @(negedge clk);
    end
    shift_dr = 0; update_dr = 1;
    @(negedge clk);
    update_dr = 0;
    if (irc == IR_DP || irc == IR_AP) begin
      chk({tag, " R3 ack"}, {29'b0, dout[2:0]}, busy_c ? 32'd1 : 32'd2);
      if (!busy_c) chk({tag, " R4 R2 captured data"}, dout[34:3], exp_d);
      model_exec(irc == IR_AP, a, rnw, wd, busy_c);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  int acc0;
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE0000 | i;
    idle(3);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset tdo", {31'b0, tdo}, 0);
    chk("R1 reset request valid", {31'b0, ap_req_valid}, 0);
    run = 1;
    // R1: status reads zero
    scan(IR_DP, 2'd1, 1, 0, "R1 read ctrl");
    scan(IR_DP, 2'd2, 1, 0, "R1 read select");
    scan(IR_DP, 2'd0, 1, 0, "R1 R5 read zero reg");
    // R7 power handshake, overrun enable
    scan(IR_DP, 2'd1, 0, 32'h5000_0001, "R7 write ctrl");
    idle(10);
    scan(IR_DP, 2'd1, 1, 0, "R7 read ctrl");
    scan(IR_DP, 2'd1, 1, 0, "R7 ctrl value");
    // R6 select
    scan(IR_DP, 2'd2, 0, 32'hFFFF_FFFF, "R6 write select");
    scan(IR_DP, 2'd2, 1, 0, "R6 read select");
    scan(IR_DP, 2'd2, 0, 32'h3C12_34A7, "R6 write select2");
    scan(IR_DP, 2'd2, 1, 0, "R6 read select2");
    // access-port write then pipelined read
    scan(IR_AP, 2'd1, 0, 32'h1234_5678, "R6 ap write");
    idle(10);
    scan(IR_AP, 2'd1, 1, 0, "R4 ap read");
    idle(10);
    scan(IR_DP, 2'd3, 1, 0, "R4 read rdbuff");
    acc0 = n_acc;
    scan(IR_DP, 2'd0, 1, 0, "R5 rdbuff result");
    idle(5);
    chk("R5 no access from rdbuff", n_acc, acc0);
    scan(IR_AP, 2'd2, 1, 0, "R4 ap read2");
    idle(10);
    scan(IR_AP, 2'd0, 1, 0, "R4 ap read3 returns read2");
    idle(10);
    // R12 ready stall
    rdy_en = 0;
    scan(IR_AP, 2'd3, 0, 32'hAAAA_5555, "R12 stalled write");
    idle(6);
    chk("R12 valid held", {31'b0, ap_req_valid}, 1);
    chk("R12 data held", ap_req_wdata, 32'hAAAA_5555);
    scan(IR_DP, 2'd1, 0, 32'h5000_0001, "R9 R12 wait while stalled");
    rdy_en = 1;
    idle(10);
    // R9 wait and overrun
    lat = 80;
    scan(IR_AP, 2'd0, 1, 0, "R9 slow read");
    scan(IR_AP, 2'd2, 0, 32'h0BAD_0BAD, "R9 dropped under wait");
    idle(100);
    lat = 2;
    scan(IR_DP, 2'd1, 1, 0, "R8 read ctrl overrun");
    acc0 = n_acc;
    scan(IR_AP, 2'd1, 0, 32'hFACE_FACE, "R11 blocked write");
    idle(8);
    chk("R11 no access while sticky", n_acc, acc0);
    scan(IR_DP, 2'd1, 0, 32'h5000_0001, "R8 write zero keeps sticky");
    scan(IR_DP, 2'd1, 1, 0, "R8 sticky kept");
    scan(IR_DP, 2'd1, 0, 32'h5000_0003, "R8 clear overrun");
    scan(IR_DP, 2'd1, 1, 0, "R8 read cleared");
    scan(IR_DP, 2'd3, 1, 0, "R8 cleared value");
    // R10 fault
    force_fault = 1;
    scan(IR_AP, 2'd0, 1, 0, "R10 faulting read");
    idle(10);
    force_fault = 0;
    scan(IR_DP, 2'd1, 1, 0, "R10 read ctrl");
    scan(IR_DP, 2'd3, 1, 0, "R10 ctrl and rdbuff");
    scan(IR_DP, 2'd0, 1, 0, "R10 rdbuff unchanged");
    scan(IR_DP, 2'd1, 0, 32'h5000_0021, "R8 clear error");
    // R13 other IR
    scan(4'h3, 2'd1, 0, 32'h0000_0000, "R13 other ir write");
    scan(4'h3, 2'd2, 0, 32'h0000_0000, "R13 other ir select");
    idle(5);
    scan(IR_DP, 2'd1, 1, 0, "R13 read ctrl");
    scan(IR_DP, 2'd2, 1, 0, "R13 ctrl unchanged");
    scan(IR_DP, 2'd0, 1, 0, "R13 select unchanged");
    scan(IR_AP, 2'd3, 1, 0, "R2 ap read after clear");
    idle(10);
    scan(IR_DP, 2'd3, 1, 0, "R2 final rdbuff");
    idle(5);
    chk("R12 all requests seen", q.size(), 0);
    run = 0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule